// File: doc/BRIEF.md
# Dual-Channel PWM Compare Output Unit

This block is a 16-bit timer/counter with two compare channels, A and B. Each channel drives one waveform pin and a flag that says whether the pin is currently driven by the unit. When the flag is low, the pin belongs to ordinary port logic elsewhere on the chip.

A 4-bit waveform mode selects how the counter moves and where its TOP value comes from:
- a free-running count;
- clear-on-match counting;
- single-slope fast PWM;
- dual-slope PWM, in either a phase-correct or a phase-and-frequency-correct variant.

A 2-bit compare action per channel decides what a compare match, and the counter's end points, do to that channel's pin. In the PWM modes the compare values are double-buffered. This lets software change a duty cycle at any time without producing a glitched period.

The unit is a bare datapath. It takes a count enable, the mode fields, a TOP register and two compare registers, and it presents the pins and the live count. Clock division, capture, interrupts and register access are left to the surrounding logic.

Top module: `pwm_compare_unit`

## Requirements
- R1: While rst_n is low the count is 0, the counter direction is up, both internal pin states are 0, both compare shadow registers are 0, and both pins read 0.
- R2: While cnt_en is low the count, direction and pin states hold. Both compare shadow registers copy cmp_a_val and cmp_b_val on every clock.
- R3: Single-slope modes count up by one per enabled clock. From a count at or above TOP they return to 0. Code 0 (and every code not named in R3 or R4) is free-running, with TOP equal to all ones. Code 4 is clear-on-match, with TOP equal to cmp_a_val. Code 14 is fast PWM with TOP equal to top_val. Code 15 is fast PWM with TOP equal to the buffered A compare value.
- R4: The dual-slope modes count up to TOP, then down to 0, then up again. At a count of 0 the next step is always upward. Code 8 is phase-and-frequency correct with TOP equal to top_val. Code 9 is the same with TOP from buffered A. Code 10 is phase correct with TOP equal to top_val. Code 11 is the same with TOP from buffered A.
- R5: In codes other than 8–11 and 14–15, a compare match (count equal to that channel's compare value) acts on the pin at the clock edge that leaves the matching count. Action 01 toggles the pin, 10 clears it and 11 sets it. Any nonzero action drives the pin.
- R6: In fast PWM, action 10 clears the pin on a match and sets it on the edge that wraps from TOP to 0. Action 11 does the opposite.
- R7: In dual-slope PWM, a match is an up-match when the counter leaves that count upward, and a down-match otherwise. A match at 0 is therefore an up-match. Action 10 clears on an up-match and sets on a down-match. Action 11 does the opposite.
- R8: In PWM modes, action 01 toggles pin A on every match only in codes 9, 11, 14 and 15. In any other PWM code, action 01 leaves pin A undriven. Channel B is never driven with action 01 in any PWM mode.
- R9: In PWM modes, when a channel's buffered compare value equals TOP and its action is 10 or 11, matches are ignored. At the TOP turning point (the wrap in fast PWM, the upward arrival in dual slope) the pin is set for 10 and cleared for 11.
- R10: In PWM modes the shadow registers load from the compare inputs at one point per period: on the wrap edge in fast PWM, on the TOP turning edge in phase correct, and on the edge that leaves 0 upward in phase-and-frequency correct.
- R11: In every mode, action 00 leaves the channel undriven, and an undriven pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; low freezes the counter and pins |
| wave_mode | input | 4 | Waveform mode code |
| com_a | input | 2 | Compare action for channel A |
| com_b | input | 2 | Compare action for channel B |
| top_val | input | 16 | TOP value for codes 8, 10, 14 |
| cmp_a_val | input | 16 | Compare value A (also TOP in codes 4, 9, 11, 15) |
| cmp_b_val | input | 16 | Compare value B |
| pin_a | output | 1 | Waveform pin A |
| pin_a_drv | output | 1 | Pin A is driven by this unit |
| pin_b | output | 1 | Waveform pin B |
| pin_b_drv | output | 1 | Pin B is driven by this unit |
| count | output | 16 | Current counter value |

## Verification
The hardest situation to reach is a compare value changing in the middle of a PWM period. The new value must not act until the mode's own load point, which differs between fast, phase-correct and phase-and-frequency-correct PWM. A second hard case is code 15, where that same buffered value also moves TOP.

The stimulus runs a few cycles into a period, rewrites both compare inputs while the count is between its end points, and keeps running across several periods. A cycle-accurate model in the bench tracks its own shadow registers. A second scenario stops the counter mid-period and rewrites the compares while it is stopped, which reaches the path where the shadows follow the inputs directly.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;

  typedef enum logic [2:0] {
    WK_NORMAL = 3'd0,
    WK_CTC    = 3'd1,
    WK_FAST   = 3'd2,
    WK_PHASE  = 3'd3,
    WK_PHFREQ = 3'd4
  } wave_kind_e;

  typedef struct packed {
    wave_kind_e kind;
    logic       top_from_a;
    logic       top_from_reg;
    logic       a_toggle_ok;
  } wave_cfg_t;

  // Mode code -> counting style and TOP source.
  function automatic wave_cfg_t decode_wave(input logic [3:0] code);
    wave_cfg_t c;
    c.kind         = WK_NORMAL;
    c.top_from_a   = 1'b0;
    c.top_from_reg = 1'b0;
    c.a_toggle_ok  = 1'b0;
    case (code)
      4'd4:  begin c.kind = WK_CTC;    c.top_from_a = 1'b1; end
      4'd8:  begin c.kind = WK_PHFREQ; c.top_from_reg = 1'b1; end
      4'd9:  begin c.kind = WK_PHFREQ; c.top_from_a = 1'b1; c.a_toggle_ok = 1'b1; end
      4'd10: begin c.kind = WK_PHASE;  c.top_from_reg = 1'b1; end
      4'd11: begin c.kind = WK_PHASE;  c.top_from_a = 1'b1; c.a_toggle_ok = 1'b1; end
      4'd14: begin c.kind = WK_FAST;   c.top_from_reg = 1'b1; c.a_toggle_ok = 1'b1; end
      4'd15: begin c.kind = WK_FAST;   c.top_from_a = 1'b1; c.a_toggle_ok = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic kind_is_pwm(input wave_kind_e k);
    return (k == WK_FAST) || (k == WK_PHASE) || (k == WK_PHFREQ);
  endfunction

  function automatic logic kind_is_dual(input wave_kind_e k);
    return (k == WK_PHASE) || (k == WK_PHFREQ);
  endfunction

  // Whether a channel owns its pin.
  function automatic logic channel_driven(input logic pwm, input logic [1:0] com,
                                          input logic tog_ok);
    logic d;
    if (com == 2'b00)      d = 1'b0;
    else if (!pwm)         d = 1'b1;
    else if (com == 2'b01) d = tog_ok;
    else                   d = 1'b1;
    return d;
  endfunction

  // Next pin state for one enabled clock.
  function automatic logic next_pin(input logic cur, input logic pwm, input logic dual,
                                    input logic [1:0] com, input logic tog_ok,
                                    input logic hit, input logic cmp_at_top,
                                    input logic turn, input logic leave_up);
    logic inv;
    logic skip;
    logic nxt;
    nxt  = cur;
    inv  = com[0];
    skip = pwm && com[1] && cmp_at_top;
    if (!pwm) begin
      case (com)
        2'b01:   if (hit) nxt = !cur;
        2'b10:   if (hit) nxt = 1'b0;
        2'b11:   if (hit) nxt = 1'b1;
        default: ;
      endcase
    end else if (com == 2'b01) begin
      if (tog_ok && hit) nxt = !cur;
    end else if (com != 2'b00) begin
      if (skip) begin
        if (turn) nxt = !inv;
      end else if (!dual) begin
        if (turn)     nxt = !inv;
        else if (hit) nxt = inv;
      end else if (hit) begin
        nxt = leave_up ? inv : !inv;
      end
    end
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dual,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             leave_up,
  output logic             turn,
  output logic             bottom_up
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  // Direction in which the counter leaves its current value.
  assign leave_up  = dual ? (up_q ? (cnt_q < top) : (cnt_q == '0)) : 1'b1;
  assign turn      = (cnt_q >= top) && (!dual || up_q);
  assign bottom_up = (cnt_q == '0) && leave_up;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!dual) begin
      up_d  = 1'b1;
      cnt_d = turn ? '0 : cnt_q + ONE;
    end else if (up_q) begin
      if (turn) begin
        up_d  = 1'b0;
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        up_d  = 1'b1;
        cnt_d = (top == '0) ? '0 : ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign count  = cnt_q;
  assign dir_up = up_q;
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             pwm,
  input  logic [CNT_W-1:0] raw,
  output logic [CNT_W-1:0] eff
);
  logic [CNT_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (load) shadow_q <= raw;
  end

  // The shadow only applies in PWM modes; otherwise compares are live.
  assign eff = pwm ? shadow_q : raw;
endmodule

// File: rtl/pwm_out_channel.sv
module pwm_out_channel
  import pwm_out_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit IS_A  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pwm,
  input  logic             dual,
  input  logic             a_tog_mode,
  input  logic [1:0]       com,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] top,
  input  logic             turn,
  input  logic             leave_up,
  output logic             pin,
  output logic             drv
);
  logic tog_ok;
  logic hit;
  logic cmp_at_top;
  logic pin_q;

  generate
    if (IS_A) begin : g_tog_a
      assign tog_ok = a_tog_mode;
    end else begin : g_tog_b
      assign tog_ok = 1'b0;
    end
  endgenerate

  assign hit        = (cnt == cmp);
  assign cmp_at_top = (cmp == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pin_q <= 1'b0;
    else if (en) pin_q <= next_pin(pin_q, pwm, dual, com, tog_ok, hit, cmp_at_top,
                                   turn, leave_up);
  end

  assign drv = channel_driven(pwm, com, tog_ok);
  assign pin = drv & pin_q;
endmodule

// File: rtl/pwm_compare_unit.sv
module pwm_compare_unit
  import pwm_out_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [3:0]       wave_mode,
  input  logic [1:0]       com_a,
  input  logic [1:0]       com_b,
  input  logic [CNT_W-1:0] top_val,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic [CNT_W-1:0] cmp_b_val,
  output logic             pin_a,
  output logic             pin_a_drv,
  output logic             pin_b,
  output logic             pin_b_drv,
  output logic [CNT_W-1:0] count
);
  localparam int NUM_CH = 2;

  wave_cfg_t cfg;
  logic      pwm;
  logic      dual;

  logic [NUM_CH-1:0][CNT_W-1:0] cmp_raw;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_eff;
  logic [NUM_CH-1:0][1:0]       com_v;
  logic [NUM_CH-1:0]            pin_v;
  logic [NUM_CH-1:0]            drv_v;

  logic [CNT_W-1:0] top_eff;
  logic [CNT_W-1:0] cmp_eff_a;
  logic             dir_up;
  logic             leave_up;
  logic             turn;
  logic             bottom_up;
  logic             shadow_load;

  assign cfg  = decode_wave(wave_mode);
  assign pwm  = kind_is_pwm(cfg.kind);
  assign dual = kind_is_dual(cfg.kind);

  assign cmp_raw   = {cmp_b_val, cmp_a_val};
  assign com_v     = {com_b, com_a};
  assign cmp_eff_a = cmp_eff[0];

  assign top_eff = cfg.top_from_a   ? cmp_eff[0] :
                   cfg.top_from_reg ? top_val    : '1;

  // Shadows follow the inputs while stopped; otherwise once per PWM period.
  assign shadow_load = !cnt_en ||
                       (pwm && ((cfg.kind == WK_PHFREQ) ? bottom_up : turn));

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cnt_en),
    .dual      (dual),
    .top       (top_eff),
    .count     (count),
    .dir_up    (dir_up),
    .leave_up  (leave_up),
    .turn      (turn),
    .bottom_up (bottom_up)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pwm_cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (shadow_load),
        .pwm   (pwm),
        .raw   (cmp_raw[ch]),
        .eff   (cmp_eff[ch])
      );

      pwm_out_channel #(.CNT_W(CNT_W), .IS_A(ch == 0)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cnt_en),
        .pwm        (pwm),
        .dual       (dual),
        .a_tog_mode (cfg.a_toggle_ok),
        .com        (com_v[ch]),
        .cnt        (count),
        .cmp        (cmp_eff[ch]),
        .top        (top_eff),
        .turn       (turn),
        .leave_up   (leave_up),
        .pin        (pin_v[ch]),
        .drv        (drv_v[ch])
      );
    end
  endgenerate

  assign pin_a     = pin_v[0];
  assign pin_a_drv = drv_v[0];
  assign pin_b     = pin_v[1];
  assign pin_b_drv = drv_v[1];
endmodule

// File: rtl/pwm_compare_unit_chk.sv
module pwm_compare_unit_chk
  import pwm_out_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [3:0]       wave_mode,
  input logic [1:0]       com_a,
  input logic [1:0]       com_b,
  input logic [CNT_W-1:0] count,
  input logic             pin_a,
  input logic             pin_b_drv,
  input logic [CNT_W-1:0] top_eff,
  input logic             dir_up,
  input logic [CNT_W-1:0] cmp_eff_a
);
  wave_cfg_t c_cfg;
  logic      c_pwm;
  logic      c_dual;

  assign c_cfg  = decode_wave(wave_mode);
  assign c_pwm  = kind_is_pwm(c_cfg.kind);
  assign c_dual = kind_is_dual(c_cfg.kind);

  // R2: a stopped counter keeps its value
  a_r2_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> count == $past(count))
    else $error("a_r2_hold_count");

  // R3: single slope returns to zero from TOP
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !c_dual && count >= top_eff) |=> count == '0)
    else $error("a_r3_wrap_zero");

  // R4: dual slope always leaves zero upward
  a_r4_bottom_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && c_dual && count == '0 && top_eff != '0) |=> dir_up)
    else $error("a_r4_bottom_up");

  // R8: channel B never owns its pin with action 01 in PWM
  a_r8_b_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pwm && com_b == 2'b01) |-> !pin_b_drv)
    else $error("a_r8_b_no_toggle");

  // R9: compare equal to TOP resolves at the turning point
  a_r9_top_action: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && c_pwm && com_a[1] && cmp_eff_a == top_eff && count >= top_eff &&
     (!c_dual || dir_up)) |=> (pin_a == !$past(com_a[0])))
    else $error("a_r9_top_action");
endmodule

bind pwm_compare_unit pwm_compare_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .wave_mode (wave_mode),
  .com_a     (com_a),
  .com_b     (com_b),
  .count     (count),
  .pin_a     (pin_a),
  .pin_b_drv (pin_b_drv),
  .top_eff   (top_eff),
  .dir_up    (dir_up),
  .cmp_eff_a (cmp_eff_a)
);

// File: tb/pwm_compare_unit_test.sv
module pwm_compare_unit_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [3:0]   wave_mode = 4'd0;
  logic [1:0]   com_a = 2'b00, com_b = 2'b00;
  logic [W-1:0] top_val = '0, cmp_a_val = '0, cmp_b_val = '0;
  logic         pin_a, pin_a_drv, pin_b, pin_b_drv;
  logic [W-1:0] count;

  always #2 clk = ~clk;

  pwm_compare_unit #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wave_mode(wave_mode),
    .com_a(com_a), .com_b(com_b), .top_val(top_val), .cmp_a_val(cmp_a_val),
    .cmp_b_val(cmp_b_val), .pin_a(pin_a), .pin_a_drv(pin_a_drv), .pin_b(pin_b),
    .pin_b_drv(pin_b_drv), .count(count)
  );

  typedef struct {
    logic [W-1:0] c;
    logic         pa, da, pb, db;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // Reference state
  logic [W-1:0] m_cnt, m_ba, m_bb;
  bit           m_dir, m_pa, m_pb;

  // 0 free-run, 1 clear-on-match, 2 fast, 3 phase, 4 phase+freq
  function automatic int kind_of(input logic [3:0] m);
    case (m)
      4'd4:         return 1;
      4'd14, 4'd15: return 2;
      4'd10, 4'd11: return 3;
      4'd8, 4'd9:   return 4;
      default:      return 0;
    endcase
  endfunction

  function automatic bit toggle_mode(input logic [3:0] m);
    return (m == 4'd9) || (m == 4'd11) || (m == 4'd14) || (m == 4'd15);
  endfunction

  function automatic bit owns(input logic [1:0] com, input bit is_a, input logic [3:0] m);
    if (com == 2'b00) return 1'b0;
    if (kind_of(m) < 2) return 1'b1;
    if (com == 2'b01) return is_a && toggle_mode(m);
    return 1'b1;
  endfunction

  function automatic bit chan(input bit cur, input logic [1:0] com, input logic [W-1:0] cv,
                              input bit is_a, input int k, input logic [3:0] m,
                              input logic [W-1:0] tp, input logic [W-1:0] c,
                              input bit turn, input bit upn);
    bit hit;
    bit inv;
    hit = (c == cv);
    inv = com[0];
    if (k < 2) begin
      if (!hit) return cur;
      if (com == 2'b01) return !cur;
      if (com == 2'b10) return 1'b0;
      if (com == 2'b11) return 1'b1;
      return cur;
    end
    if (com == 2'b00) return cur;
    if (com == 2'b01) return (is_a && toggle_mode(m) && hit) ? !cur : cur;
    if (cv == tp) return turn ? !inv : cur;
    if (k == 2) begin
      if (turn) return !inv;
      return hit ? inv : cur;
    end
    if (hit) return upn ? inv : !inv;
    return cur;
  endfunction

  task automatic model_step();
    int k;
    bit dual, upn, turn, ld;
    logic [W-1:0] ea, eb, tp;
    k    = kind_of(wave_mode);
    dual = (k >= 3);
    ea   = (k >= 2) ? m_ba : cmp_a_val;
    eb   = (k >= 2) ? m_bb : cmp_b_val;
    if (k == 0)           tp = '1;
    else if (k == 1)      tp = cmp_a_val;
    else if (wave_mode[0]) tp = ea;
    else                  tp = top_val;
    if (!cnt_en) begin
      m_ba = cmp_a_val;
      m_bb = cmp_b_val;
      return;
    end
    if (!dual) upn = 1'b1;
    else       upn = m_dir ? (m_cnt < tp) : (m_cnt == 0);
    turn = (m_cnt >= tp) && (!dual || m_dir);
    m_pa = chan(m_pa, com_a, ea, 1'b1, k, wave_mode, tp, m_cnt, turn, upn);
    m_pb = chan(m_pb, com_b, eb, 1'b0, k, wave_mode, tp, m_cnt, turn, upn);
    ld = ((k == 2 || k == 3) && turn) || (k == 4 && m_cnt == 0 && upn);
    if (ld) begin
      m_ba = cmp_a_val;
      m_bb = cmp_b_val;
    end
    if (!dual) begin
      m_dir = 1'b1;
      m_cnt = turn ? '0 : m_cnt + 1'b1;
    end else if (upn) begin
      m_dir = 1'b1;
      m_cnt = (m_cnt == 0 && !m_dir) ? ((tp == 0) ? '0 : 16'd1) : m_cnt + 1'b1;
    end else begin
      m_dir = 1'b0;
      m_cnt = (m_cnt == 0) ? '0 : m_cnt - 1'b1;
    end
  endtask

  // Driver: one cycle of stimulus plus expected result into the scoreboard
  task automatic cyc(input string tag);
    exp_t e;
    model_step();
    e.c   = m_cnt;
    e.da  = owns(com_a, 1'b1, wave_mode);
    e.db  = owns(com_b, 1'b0, wave_mode);
    e.pa  = e.da && m_pa;
    e.pb  = e.db && m_pb;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (count !== e.c || pin_a !== e.pa || pin_a_drv !== e.da ||
          pin_b !== e.pb || pin_b_drv !== e.db) begin
        n_fail++;
        $display("FAIL %s: got cnt=%0d a=%b/%b b=%b/%b, expected cnt=%0d a=%b/%b b=%b/%b",
                 e.tag, count, pin_a, pin_a_drv, pin_b, pin_b_drv,
                 e.c, e.pa, e.da, e.pb, e.db);
      end
    end
  end

  task automatic setup(input logic [3:0] m, input logic [W-1:0] tv, input logic [W-1:0] ca,
                       input logic [W-1:0] cb, input logic [1:0] ma, input logic [1:0] mb);
    @(negedge clk);
    rst_n = 1'b0;
    cnt_en = 1'b0;
    wave_mode = m; top_val = tv; cmp_a_val = ca; cmp_b_val = cb;
    com_a = ma; com_b = mb;
    m_cnt = '0; m_dir = 1'b1; m_pa = 1'b0; m_pb = 1'b0; m_ba = '0; m_bb = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (count !== '0 || pin_a !== 1'b0 || pin_b !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got cnt=%0d a=%b b=%b, expected cnt=0 a=0 b=0",
               count, pin_a, pin_b);
    end
    run("R2 stopped load", 2);
    cnt_en = 1'b1;
  endtask

  initial begin
    // R5 / R3: free-running
    setup(4'd0, 16'd0, 16'd3, 16'd7, 2'b01, 2'b11);
    run("R5 free-run toggle/set", 30);
    // R3: an undefined code behaves as free-running
    setup(4'd6, 16'd5, 16'd2, 16'd4, 2'b10, 2'b01);
    run("R3 undefined code", 20);
    // R3 / R5: clear-on-match with TOP from A
    setup(4'd4, 16'd0, 16'd9, 16'd4, 2'b01, 2'b11);
    run("R3 R5 clear-on-match", 50);
    setup(4'd4, 16'd0, 16'd6, 16'd6, 2'b10, 2'b01);
    run("R5 clear-on-match clear", 30);
    // R6: fast PWM
    setup(4'd14, 16'd15, 16'd5, 16'd0, 2'b10, 2'b11);
    run("R6 fast PWM", 70);
    // R9: fast PWM, compare equal to TOP
    setup(4'd14, 16'd15, 16'd15, 16'd15, 2'b10, 2'b11);
    run("R9 fast at TOP", 40);
    // R8: toggle in code 15, B undriven
    setup(4'd15, 16'd0, 16'd12, 16'd5, 2'b01, 2'b01);
    run("R8 fast toggle A", 60);
    // R8 / R11: action 01 in code 10 and action 00
    setup(4'd14, 16'd9, 16'd4, 16'd3, 2'b00, 2'b01);
    run("R11 disconnected", 25);
    setup(4'd10, 16'd9, 16'd4, 16'd3, 2'b01, 2'b00);
    run("R8 R11 no toggle code 10", 30);
    // R7 / R4: phase correct
    setup(4'd10, 16'd10, 16'd4, 16'd0, 2'b10, 2'b11);
    run("R7 R4 phase correct", 70);
    // R9: dual slope, compare equal to TOP
    setup(4'd10, 16'd10, 16'd10, 16'd10, 2'b10, 2'b11);
    run("R9 dual at TOP", 50);
    // R8: toggle in code 11
    setup(4'd11, 16'd0, 16'd8, 16'd3, 2'b01, 2'b10);
    run("R8 dual toggle A", 60);
    // R4 / R7: code 9 with TOP from A
    setup(4'd9, 16'd0, 16'd7, 16'd2, 2'b11, 2'b10);
    run("R4 R7 phase+freq from A", 50);
    // R10: shadow loading in each PWM variant
    setup(4'd8, 16'd9, 16'd3, 16'd6, 2'b10, 2'b11);
    run("R10 phase+freq", 14);
    cmp_a_val = 16'd7; cmp_b_val = 16'd2;
    run("R10 phase+freq update", 50);
    setup(4'd10, 16'd9, 16'd3, 16'd6, 2'b10, 2'b11);
    run("R10 phase correct", 5);
    cmp_a_val = 16'd8; cmp_b_val = 16'd1;
    run("R10 phase correct update", 50);
    setup(4'd14, 16'd11, 16'd3, 16'd6, 2'b10, 2'b11);
    run("R10 fast", 5);
    cmp_a_val = 16'd9; cmp_b_val = 16'd0;
    run("R10 fast update", 40);
    setup(4'd15, 16'd0, 16'd9, 16'd4, 2'b01, 2'b10);
    run("R10 fast TOP from A", 4);
    cmp_a_val = 16'd5; cmp_b_val = 16'd2;
    run("R10 fast TOP from A update", 40);
    // R2: stopping mid-period
    setup(4'd14, 16'd9, 16'd4, 16'd6, 2'b10, 2'b11);
    run("R2 running", 7);
    cnt_en = 1'b0;
    run("R2 stopped", 3);
    cmp_a_val = 16'd2; cmp_b_val = 16'd8;
    run("R2 stopped new compare", 3);
    cnt_en = 1'b1;
    run("R2 resumed", 40);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule